// File: doc/BRIEF.md
# DMA Channel Trigger Select Latch

This block is the trigger front end shared by the channels of a multi-channel DMA controller. Each channel carries a select code that routes one of a set of peripheral event lines to it. Three of those lines are external interrupts that can come from general-purpose pins. A rising edge on the routed line sets a sticky pending flag for that channel. While the channel's trigger enable and run status are both high, the pending flag is shown to the channel engine as a service request.

When the engine takes a request, it returns a one-cycle accept pulse. That pulse clears the pending flag. In the same cycle the block sends a one-cycle clear pulse to the source the channel has selected, so that the source can signal again. Software has a force strobe and a clear strobe for each channel. Both act on the pending flag whatever the select code holds.

The address engine, arbitration between channels and register decode all sit outside this block. They reach it as plain inputs and outputs.

Top module: `dma_trig_front`

## Requirements
- R1: While rst_ni is low, pend_o, req_o and src_clr_o are all zero.
- R2: A select code k in the range 1 to 29 routes evt_i[k-1] to the channel. A rising edge on that line sets the channel's pend_o at the next clock edge.
- R3: Select code 0 and codes 30 and 31 route no source. Events never set pend_o for that channel.
- R4: Events are edge-detected. A line held high sets pend_o only once for each low-to-high transition.
- R5: req_o[c] is high in exactly the cycles where pend_o[c], trig_en_i[c] and run_i[c] are all high.
- R6: When accept_i[c] is high while req_o[c] is high, pend_o[c] clears at the next edge. In that same cycle src_clr_o[k-1] is high for the selected code k (1 to 29), and for one cycle only. accept_i has no effect while req_o[c] is low.
- R7: force_i[c] sets pend_o[c] at the next edge, whatever the select code.
- R8: clr_i[c] clears pend_o[c] at the next edge, whatever the select code.
- R9: If an event or force_i arrives in the same cycle as clr_i or a taken accept, the set wins and pend_o stays high.
- R10: Channels are independent. Any stimulus on one channel's strobes or select code leaves every other channel's pending flag unchanged.
- R11: Once set, pend_o stays high until a clear strobe or a taken accept removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Peripheral event lines; code k selects bit k-1 |
| sel_i | input | NUM_CH*SEL_W | Select codes; channel c at [c*SEL_W +: SEL_W] |
| trig_en_i | input | NUM_CH | Trigger enable for each channel |
| run_i | input | NUM_CH | Run status for each channel |
| force_i | input | NUM_CH | Software force strobe |
| clr_i | input | NUM_CH | Software clear strobe |
| accept_i | input | NUM_CH | Engine accept pulse |
| pend_o | output | NUM_CH | Pending flag for each channel |
| req_o | output | NUM_CH | Service request to the channel engine |
| src_clr_o | output | NUM_SRC | Clear pulse back to each event source |

## Verification
A pending flag that is wrongly set or wrongly lost shows up on pend_o one clock after the stimulus that caused it. The same error appears on req_o in that cycle whenever enable and run are high. A bad select decode shows up in two places. One is a flag raised by the wrong line. The other is a src_clr_o pulse on the wrong bit, seen combinationally in the cycle of the accept. If the edge detector stays stuck, a held level keeps re-arming the flag on the cycle right after a clear or accept.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;
  typedef struct packed {
    logic hw_hit;
    logic sw_set;
    logic sw_clr;
    logic take;
  } pend_ctl_t;
endpackage

// File: rtl/dma_trig_edge.sv
module dma_trig_edge #(
  parameter int unsigned W = 29
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/dma_trig_sel.sv
module dma_trig_sel #(
  parameter int unsigned NUM_SRC = 29,
  parameter int unsigned SEL_W   = 5
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_SRC-1:0] rise_i,
  output logic [NUM_SRC-1:0] dec_o,
  output logic               hit_o
);
  // code 0 and codes above NUM_SRC decode to nothing
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_dec
    assign dec_o[k] = (sel_i == SEL_W'(k + 1));
  end

  assign hit_o = |(dec_o & rise_i);
endmodule

// File: rtl/dma_trig_chan.sv
module dma_trig_chan
  import dma_trig_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pend_ctl_t ctl_i,
  input  logic      en_i,
  input  logic      run_i,
  output logic      pend_o,
  output logic      req_o
);
  logic pend_q;
  logic set_w;
  logic drop_w;

  assign set_w  = ctl_i.hw_hit | ctl_i.sw_set;
  assign drop_w = ctl_i.sw_clr | ctl_i.take;

  // set has priority so a coincident event is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_w)  pend_q <= 1'b1;
    else if (drop_w) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign req_o  = pend_q & en_i & run_i;
endmodule

// File: rtl/dma_trig_front.sv
module dma_trig_front
  import dma_trig_pkg::*;
#(
  parameter int unsigned NUM_CH  = 6,
  parameter int unsigned NUM_SRC = 29,
  parameter int unsigned SEL_W   = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_SRC-1:0]      evt_i,
  input  logic [NUM_CH*SEL_W-1:0] sel_i,
  input  logic [NUM_CH-1:0]       trig_en_i,
  input  logic [NUM_CH-1:0]       run_i,
  input  logic [NUM_CH-1:0]       force_i,
  input  logic [NUM_CH-1:0]       clr_i,
  input  logic [NUM_CH-1:0]       accept_i,
  output logic [NUM_CH-1:0]       pend_o,
  output logic [NUM_CH-1:0]       req_o,
  output logic [NUM_SRC-1:0]      src_clr_o
);
  logic [NUM_SRC-1:0] rise_w;
  logic [NUM_SRC-1:0] dec_w  [NUM_CH];
  logic [NUM_SRC-1:0] ack_w  [NUM_CH];
  logic [NUM_CH-1:0]  hit_w;
  logic [NUM_CH-1:0]  take_w;

  dma_trig_edge #(.W(NUM_SRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (evt_i),
    .rise_o (rise_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pend_ctl_t ctl;

    dma_trig_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
      .sel_i  (sel_i[c*SEL_W +: SEL_W]),
      .rise_i (rise_w),
      .dec_o  (dec_w[c]),
      .hit_o  (hit_w[c])
    );

    assign take_w[c]  = accept_i[c] & req_o[c];
    assign ctl.hw_hit = hit_w[c];
    assign ctl.sw_set = force_i[c];
    assign ctl.sw_clr = clr_i[c];
    assign ctl.take   = take_w[c];
    assign ack_w[c]   = dec_w[c] & {NUM_SRC{take_w[c]}};

    dma_trig_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ctl_i  (ctl),
      .en_i   (trig_en_i[c]),
      .run_i  (run_i[c]),
      .pend_o (pend_o[c]),
      .req_o  (req_o[c])
    );
  end

  always_comb begin
    src_clr_o = '0;
    for (int c = 0; c < NUM_CH; c++) src_clr_o |= ack_w[c];
  end
endmodule

// File: rtl/dma_trig_front_chk.sv
module dma_trig_front_chk #(
  parameter int unsigned NUM_CH  = 6,
  parameter int unsigned NUM_SRC = 29,
  parameter int unsigned SEL_W   = 5
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_SRC-1:0]      evt_i,
  input logic [NUM_CH*SEL_W-1:0] sel_i,
  input logic [NUM_CH-1:0]       trig_en_i,
  input logic [NUM_CH-1:0]       run_i,
  input logic [NUM_CH-1:0]       force_i,
  input logic [NUM_CH-1:0]       clr_i,
  input logic [NUM_CH-1:0]       accept_i,
  input logic [NUM_CH-1:0]       pend_o,
  input logic [NUM_CH-1:0]       req_o,
  input logic [NUM_SRC-1:0]      src_clr_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R5
    req_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o[c] |-> (trig_en_i[c] && run_i[c] && pend_o[c]));
    // R7
    force_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_i[c] |=> pend_o[c]);
    // R8
    sw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[c] && !force_i[c] && evt_i == '0) |=> !pend_o[c]);
    // R6
    take_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_i[c] && req_o[c] && !force_i[c] && evt_i == '0) |=> !pend_o[c]);
    // R11
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[c] && !clr_i[c] && !(accept_i[c] && req_o[c])) |=> pend_o[c]);
  end

  // R6
  src_clr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_clr_o) |-> (|(accept_i & req_o)));
endmodule

bind dma_trig_front dma_trig_front_chk #(
  .NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/dma_trig_front_tb.sv
`timescale 1ns/1ps
module dma_trig_front_tb;
  localparam int NCH = 6;
  localparam int NSRC = 29;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] evt = '0;
  logic [SW-1:0] sel_a [NCH];
  logic [NCH*SW-1:0] sel;
  logic [NCH-1:0] en = '0, run = '0, frc = '0, clr = '0, acc = '0;
  logic [NCH-1:0] pend, req;
  logic [NSRC-1:0] sclr;

  logic [NCH-1:0] m_pend;
  logic [NSRC-1:0] m_prev;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb
    for (int c = 0; c < NCH; c++) sel[c*SW +: SW] = sel_a[c];

  dma_trig_front u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .sel_i(sel),
    .trig_en_i(en), .run_i(run), .force_i(frc), .clr_i(clr),
    .accept_i(acc), .pend_o(pend), .req_o(req), .src_clr_o(sclr)
  );

  function automatic logic valid_code(logic [SW-1:0] s);
    return (s >= 1) && (s <= NSRC);
  endfunction

  function automatic logic [NCH-1:0] exp_req();
    return m_pend & en & run;
  endfunction

  function automatic logic [NSRC-1:0] exp_sclr();
    logic [NSRC-1:0] r = '0;
    logic [NCH-1:0] q = exp_req();
    for (int c = 0; c < NCH; c++)
      if (acc[c] && q[c] && valid_code(sel_a[c])) r[sel_a[c]-1] = 1'b1;
    return r;
  endfunction

  function automatic logic [NCH-1:0] next_pend();
    logic [NCH-1:0] n = m_pend;
    logic [NSRC-1:0] rise = evt & ~m_prev;
    logic [NCH-1:0] q = exp_req();
    for (int c = 0; c < NCH; c++) begin
      logic hit = valid_code(sel_a[c]) && rise[sel_a[c]-1];
      if (hit || frc[c]) n[c] = 1'b1;
      else if (clr[c] || (acc[c] && q[c])) n[c] = 1'b0;
    end
    return n;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // inputs already driven at negedge; checks comb, clocks, checks pend
  task automatic step(string tag);
    #1;
    chk(tag, "req_o", 64'(req), 64'(exp_req()));
    chk(tag, "src_clr_o", 64'(sclr), 64'(exp_sclr()));
    @(posedge clk);
    m_pend = next_pend();
    m_prev = evt;
    @(negedge clk);
    chk(tag, "pend_o", 64'(pend), 64'(m_pend));
  endtask

  task automatic idle_strobes();
    frc = '0; clr = '0; acc = '0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < NCH; c++) sel_a[c] = '0;
    m_pend = '0; m_prev = '0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "pend_o", 64'(pend), 64'd0);
    chk("R1", "req_o", 64'(req), 64'd0);
    chk("R1", "src_clr_o", 64'(sclr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    en = '1; run = '1;

    // R2: code 5 -> evt[4]
    sel_a[0] = 5'd5; evt[4] = 1'b1; step("R2");
    evt[4] = 1'b0; step("R2");
    // R5: run drop hides request
    run[0] = 1'b0; step("R5");
    run[0] = 1'b1; step("R5");
    // R6: accept, clear pulse on bit 4
    acc[0] = 1'b1; step("R6");
    acc[0] = 1'b0; step("R6");
    // R6: accept without request has no effect
    en[2] = 1'b0; frc[2] = 1'b1; step("R7");
    frc[2] = 1'b0; acc[2] = 1'b1; step("R6");
    acc[2] = 1'b0; en[2] = 1'b1; clr[2] = 1'b1; step("R8");
    clr[2] = 1'b0;
    // R3: code 0 and code 30 route nothing
    sel_a[1] = 5'd0; sel_a[2] = 5'd30; sel_a[0] = 5'd0;
    evt = '1; step("R3");
    evt = '0; step("R3");
    sel_a[2] = 5'd31; evt = '1; step("R3");
    evt = '0; step("R3");
    // R4: held level sets once
    sel_a[3] = 5'd8; evt[7] = 1'b1; step("R4");
    clr[3] = 1'b1; step("R4");
    clr[3] = 1'b0;
    repeat (4) step("R4");
    evt[7] = 1'b0; step("R4");
    // R7 / R8 with no source
    sel_a[4] = 5'd0; frc[4] = 1'b1; step("R7");
    frc[4] = 1'b0; step("R11");
    repeat (3) step("R11");
    clr[4] = 1'b1; step("R8");
    // R9: set beats clear
    frc[4] = 1'b1; clr[4] = 1'b1; step("R9");
    frc[4] = 1'b0; clr[4] = 1'b0;
    sel_a[5] = 5'd29; evt[28] = 1'b1; step("R2");
    evt[28] = 1'b0; clr[5] = 1'b1; step("R8");
    clr[5] = 1'b0; evt[28] = 1'b1; acc[4] = 1'b1; step("R9");
    evt[28] = 1'b1; clr[5] = 1'b1; acc[4] = 1'b0; step("R9");
    idle_strobes(); evt = '0; step("R9");

    // R10: random mix across all channels
    for (int i = 0; i < 3000; i++) begin
      evt = evt ^ NSRC'($urandom & $urandom);
      for (int c = 0; c < NCH; c++)
        if (($urandom & 7) == 0) sel_a[c] = SW'($urandom_range(0, 31));
      en  = ~NCH'($urandom & $urandom & $urandom);
      run = ~NCH'($urandom & $urandom & $urandom);
      frc = NCH'($urandom & $urandom & $urandom);
      clr = NCH'($urandom & $urandom & $urandom);
      acc = NCH'($urandom);
      step("R10");
    end
    idle_strobes();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule